// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

The block sends one left and one right 16-bit audio word per frame over a single serial data line. A frame lasts 128 periods of the internal sample clock, which is given as a clock enable (`clki_en`) on the system clock. The frame holds 64 bit-clock slots: the first 32 belong to the left word and the last 32 to the right word. Both words of a frame come from one pair that was loaded together. The pair is written into a holding stage with a load strobe. It moves into the transmit stage only at the start of a frame, so a load in the middle of a frame leaves the frame in progress intact.

Four static mode inputs select the line format, giving sixteen combinations. As master, the block generates the frame sync and the bit clock itself. As slave, it takes both from outside, passes each through a two-stage synchroniser clocked by the sample-clock enable, and follows them. The frame sync either rises together with the first left bit or one bit clock earlier. Each word sits either at the front or at the back of its 32-slot half. Unused slots are either driven low or released to high impedance through `sdo_oe`. With the back-justified/front-justified choice and high-impedance idle, two transmitters in slave mode can share one data wire.

Top module: `stereo_serial_tx`

## Requirements
- R1: In master mode `sclk_o` toggles on every enabled clock edge, so one slot lasts two `clki_en` periods and starts when `sclk_o` rises; a frame is 64 slots. No output changes on an edge where `clki_en` is low, except when forced by `pwr_dn`.
- R2: Slots 0 to 31 carry the left word and slots 32 to 63 the right word, most significant bit first. With `mode_sync_coinc`=1, `sync_o` is high for slots 0 to 31 and rises at the start of slot 0.
- R3: With `mode_sync_coinc`=0, `sync_o` is high for slot 63 and slots 0 to 30, so it rises one slot before the first left bit.
- R4: With `mode_right_just`=0, a word uses positions 0 to 15 of its half and position p carries bit 15-p. With `mode_right_just`=1, it uses positions 16 to 31 and position p carries bit 31-p.
- R5: In data positions `sdo_oe`=1. In the other positions `sdo`=0, and `sdo_oe` equals `mode_idle_low`.
- R6: A `smp_load` pulse captures both words. The pair is transferred to the transmit stage at the start of slot 0, so a load during a frame changes only the frames that follow it.
- R7: With `mode_slave`=1, `ext_sclk` and `ext_sync` are resampled on `clki_en` by two-stage synchronisers. Each resampled `ext_sclk` rise starts the next slot. The resampled sync level is taken at those rises, and a low-to-high change sets the slot to 0 (`mode_sync_coinc`=1) or to 63 (`mode_sync_coinc`=0). `sdo` follows within three enables of the external edge.
- R8: In slave mode `sync_o` and `sclk_o` are held low.
- R9: During reset or `pwr_dn`, `sdo`, `sdo_oe`, `sync_o` and `sclk_o` are low. In master mode, the first enabled edge after `pwr_dn` is released starts slot 0 of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clki_en | input | 1 | Internal sample-clock enable |
| pwr_dn | input | 1 | Power-down: outputs quiet, timebase restarted |
| left_smp | input | 16 | Left sample word |
| right_smp | input | 16 | Right sample word |
| smp_load | input | 1 | Captures the sample pair into the holding stage |
| mode_sync_coinc | input | 1 | 1: sync rises with the first bit; 0: one slot earlier |
| mode_slave | input | 1 | 1: follow the external sync and bit clock |
| mode_right_just | input | 1 | 1: word at the back of its half |
| mode_idle_low | input | 1 | 1: drive low in unused slots; 0: release the line |
| ext_sync | input | 1 | External frame sync (slave mode) |
| ext_sclk | input | 1 | External bit clock (slave mode) |
| sync_o | output | 1 | Frame sync out (master mode) |
| sclk_o | output | 1 | Bit clock out (master mode) |
| sdo | output | 1 | Serial data |
| sdo_oe | output | 1 | Output enable for `sdo` |

## Verification
In slave mode a resampled sync rise and a resampled bit-clock rise reach the slot logic in the same enable. The slot counter must then take the realigned value instead of its increment. The bench provokes this by changing `ext_sync` and raising `ext_sclk` on the same clock, in both sync formats. It judges the result by comparing a whole later frame of `sdo` and `sdo_oe`, slot by slot, against a frame computed from the requirements. The start of a frame is a second such meeting point, because there the transfer of the words and the choice of the first bit fall on one edge. Sampling the first bit right after power-down is released checks it.

// File: rtl/sst_pkg.sv
package sst_pkg;
  typedef struct packed {
    logic sync_coinc;
    logic slave;
    logic right_just;
    logic idle_low;
  } sst_mode_t;
endpackage

// File: rtl/sst_resync.sv
module sst_resync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] st_q, st_d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_comb st_d[i] = clr ? 1'b0 : (en ? d : st_q[i]);
    end else begin : g_rest
      always_comb st_d[i] = clr ? 1'b0 : (en ? st_q[i-1] : st_q[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/sst_timebase.sv
module sst_timebase
  import sst_pkg::*;
#(
  parameter int SLOT_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clki_en,
  input  logic              pwr_dn,
  input  sst_mode_t         mode,
  input  logic              ext_sync,
  input  logic              ext_sclk,
  output logic              adv,
  output logic [SLOT_W-1:0] slot_eff,
  output logic              m_sclk_nxt
);
  localparam int PH_W = SLOT_W + 1;

  logic [PH_W-1:0]   ph_q, ph_d, ph_inc;
  logic [SLOT_W-1:0] slot_q, slot_d, s_next;
  logic              yprev_q, yprev_d;
  logic              sclk_last_q, sclk_last_d;
  logic              sclk_rs, sync_rs, s_rise, s_realign;

  sst_resync #(.STAGES(SYNC_STAGES)) u_rs_sclk (
    .clk(clk), .rst_n(rst_n), .en(clki_en), .clr(pwr_dn), .d(ext_sclk), .q(sclk_rs)
  );
  sst_resync #(.STAGES(SYNC_STAGES)) u_rs_sync (
    .clk(clk), .rst_n(rst_n), .en(clki_en), .clr(pwr_dn), .d(ext_sync), .q(sync_rs)
  );

  // slot decode: master from the phase counter, slave from resampled edges
  always_comb begin
    ph_inc     = ph_q + 1'b1;
    s_rise     = sclk_rs & ~sclk_last_q;
    s_realign  = sync_rs & ~yprev_q;
    s_next     = s_realign ? (mode.sync_coinc ? '0 : '1) : slot_q + 1'b1;
    m_sclk_nxt = ~ph_inc[0];
    adv        = mode.slave ? s_rise : ~ph_inc[0];
    slot_eff   = mode.slave ? (s_rise ? s_next : slot_q) : ph_inc[PH_W-1:1];
  end

  // next state
  always_comb begin
    ph_d        = ph_q;
    slot_d      = slot_q;
    yprev_d     = yprev_q;
    sclk_last_d = sclk_last_q;
    if (pwr_dn) begin
      ph_d        = '1;
      slot_d      = '1;
      yprev_d     = 1'b0;
      sclk_last_d = 1'b0;
    end else if (clki_en) begin
      ph_d        = ph_inc;
      sclk_last_d = sclk_rs;
      if (s_rise) begin
        slot_d  = s_next;
        yprev_d = sync_rs;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q        <= '1;
      slot_q      <= '1;
      yprev_q     <= 1'b0;
      sclk_last_q <= 1'b0;
    end else begin
      ph_q        <= ph_d;
      slot_q      <= slot_d;
      yprev_q     <= yprev_d;
      sclk_last_q <= sclk_last_d;
    end
  end
endmodule

// File: rtl/sst_word_hold.sv
module sst_word_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_load,
  input  logic [W-1:0] left_in,
  input  logic [W-1:0] right_in,
  input  logic         xfer,
  output logic [W-1:0] left_nxt,
  output logic [W-1:0] right_nxt
);
  logic [W-1:0] hold_l_q, hold_l_d, hold_r_q, hold_r_d;
  logic [W-1:0] tx_l_q, tx_l_d, tx_r_q, tx_r_d;

  always_comb begin
    hold_l_d = smp_load ? left_in  : hold_l_q;
    hold_r_d = smp_load ? right_in : hold_r_q;
    tx_l_d   = xfer ? hold_l_q : tx_l_q;
    tx_r_d   = xfer ? hold_r_q : tx_r_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l_q <= '0;
      hold_r_q <= '0;
      tx_l_q   <= '0;
      tx_r_q   <= '0;
    end else begin
      hold_l_q <= hold_l_d;
      hold_r_q <= hold_r_d;
      tx_l_q   <= tx_l_d;
      tx_r_q   <= tx_r_d;
    end
  end

  assign left_nxt  = tx_l_d;
  assign right_nxt = tx_r_d;
endmodule

// File: rtl/sst_slot_encoder.sv
module sst_slot_encoder
  import sst_pkg::*;
#(
  parameter int W      = 16,
  parameter int SLOT_W = 6
) (
  input  logic [SLOT_W-1:0] slot,
  input  sst_mode_t         mode,
  input  logic [W-1:0]      left_w,
  input  logic [W-1:0]      right_w,
  output logic              sdo_bit,
  output logic              oe,
  output logic              sync_lvl
);
  localparam int POS_W = SLOT_W - 1;
  localparam int HALF  = 2 * W;
  localparam int IDX_W = $clog2(W);

  logic             half, in_data;
  logic [POS_W-1:0] pos;
  logic [IDX_W-1:0] idx;
  logic [W-1:0]     word;

  always_comb begin
    half     = slot[SLOT_W-1];
    pos      = slot[POS_W-1:0];
    word     = half ? right_w : left_w;
    in_data  = mode.right_just ? (pos >= POS_W'(W)) : (pos < POS_W'(W));
    idx      = mode.right_just ? IDX_W'(POS_W'(HALF - 1) - pos)
                               : IDX_W'(POS_W'(W - 1) - pos);
    sdo_bit  = in_data & word[idx];
    oe       = in_data | mode.idle_low;
    sync_lvl = mode.sync_coinc ? ~half : ((&slot) | (~half & ~(&pos)));
  end
endmodule

// File: rtl/stereo_serial_tx.sv
module stereo_serial_tx
  import sst_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clki_en,
  input  logic              pwr_dn,
  input  logic [WORD_W-1:0] left_smp,
  input  logic [WORD_W-1:0] right_smp,
  input  logic              smp_load,
  input  logic              mode_sync_coinc,
  input  logic              mode_slave,
  input  logic              mode_right_just,
  input  logic              mode_idle_low,
  input  logic              ext_sync,
  input  logic              ext_sclk,
  output logic              sync_o,
  output logic              sclk_o,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int SLOT_W = $clog2(4 * WORD_W);

  sst_mode_t         mode;
  logic              adv, m_sclk_nxt, xfer;
  logic [SLOT_W-1:0] slot_eff;
  logic [WORD_W-1:0] left_nxt, right_nxt;
  logic              enc_sdo, enc_oe, enc_sync;
  logic              sdo_q, sdo_d, oe_q, oe_d, sync_q, sync_d, sclk_q, sclk_d;

  assign mode = '{sync_coinc: mode_sync_coinc, slave: mode_slave,
                  right_just: mode_right_just, idle_low: mode_idle_low};

  sst_timebase #(.SLOT_W(SLOT_W), .SYNC_STAGES(SYNC_STAGES)) u_timebase (
    .clk(clk), .rst_n(rst_n), .clki_en(clki_en), .pwr_dn(pwr_dn), .mode(mode),
    .ext_sync(ext_sync), .ext_sclk(ext_sclk),
    .adv(adv), .slot_eff(slot_eff), .m_sclk_nxt(m_sclk_nxt)
  );

  assign xfer = clki_en & ~pwr_dn & adv & (slot_eff == '0);

  sst_word_hold #(.W(WORD_W)) u_word_hold (
    .clk(clk), .rst_n(rst_n), .smp_load(smp_load),
    .left_in(left_smp), .right_in(right_smp), .xfer(xfer),
    .left_nxt(left_nxt), .right_nxt(right_nxt)
  );

  sst_slot_encoder #(.W(WORD_W), .SLOT_W(SLOT_W)) u_encoder (
    .slot(slot_eff), .mode(mode), .left_w(left_nxt), .right_w(right_nxt),
    .sdo_bit(enc_sdo), .oe(enc_oe), .sync_lvl(enc_sync)
  );

  // output stage: updates only on the sample-clock enable
  always_comb begin
    sdo_d  = sdo_q;
    oe_d   = oe_q;
    sync_d = sync_q;
    sclk_d = sclk_q;
    if (pwr_dn) begin
      sdo_d  = 1'b0;
      oe_d   = 1'b0;
      sync_d = 1'b0;
      sclk_d = 1'b0;
    end else if (clki_en) begin
      sdo_d  = enc_sdo;
      oe_d   = enc_oe;
      sync_d = mode_slave ? 1'b0 : enc_sync;
      sclk_d = mode_slave ? 1'b0 : m_sclk_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo_q  <= 1'b0;
      oe_q   <= 1'b0;
      sync_q <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      sdo_q  <= sdo_d;
      oe_q   <= oe_d;
      sync_q <= sync_d;
      sclk_q <= sclk_d;
    end
  end

  assign sdo    = sdo_q;
  assign sdo_oe = oe_q;
  assign sync_o = sync_q;
  assign sclk_o = sclk_q;
endmodule

// File: rtl/sst_checker.sv
module sst_checker (
  input logic clk,
  input logic rst_n,
  input logic clki_en,
  input logic pwr_dn,
  input logic mode_slave,
  input logic mode_idle_low,
  input logic sync_o,
  input logic sclk_o,
  input logic sdo,
  input logic sdo_oe
);
  a_r9_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (!sdo_oe && !sdo && !sync_o && !sclk_o));

  a_r8_slave_pins_low: assert property (@(posedge clk) disable iff (!rst_n)
    (clki_en && mode_slave && !pwr_dn) |=> (!sync_o && !sclk_o));

  a_r1_hold_without_en: assert property (@(posedge clk) disable iff (!rst_n)
    (!clki_en && !pwr_dn) |=> $stable({sdo, sdo_oe, sync_o, sclk_o}));

  a_r5_idle_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (clki_en && !pwr_dn && mode_idle_low) |=> sdo_oe);

  a_r5_released_is_low: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);
endmodule

bind stereo_serial_tx sst_checker u_sst_checker (
  .clk(clk), .rst_n(rst_n), .clki_en(clki_en), .pwr_dn(pwr_dn),
  .mode_slave(mode_slave), .mode_idle_low(mode_idle_low),
  .sync_o(sync_o), .sclk_o(sclk_o), .sdo(sdo), .sdo_oe(sdo_oe)
);

// File: tb/stereo_serial_tx_bench.sv
module stereo_serial_tx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clki_en = 1'b1;
  logic pwr_dn = 1'b0;
  logic [15:0] left_smp = '0, right_smp = '0;
  logic smp_load = 1'b0;
  logic m_coinc = 1'b1, m_slave = 1'b0, m_rj = 1'b0, m_idle = 1'b0;
  logic ext_sync = 1'b0, ext_sclk = 1'b0;
  logic sync_o, sclk_o, sdo, sdo_oe;

  int n_checks = 0;
  int n_err = 0;
  int div = 1;
  int en_cnt = 0;
  bit done = 0;

  stereo_serial_tx u_stereo_serial_tx (
    .clk(clk), .rst_n(rst_n), .clki_en(clki_en), .pwr_dn(pwr_dn),
    .left_smp(left_smp), .right_smp(right_smp), .smp_load(smp_load),
    .mode_sync_coinc(m_coinc), .mode_slave(m_slave), .mode_right_just(m_rj),
    .mode_idle_low(m_idle), .ext_sync(ext_sync), .ext_sclk(ext_sclk),
    .sync_o(sync_o), .sclk_o(sclk_o), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    en_cnt = (en_cnt + 1) % div;
    clki_en = (en_cnt == 0);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic void expect_slot(input int k, input logic [15:0] l, r,
                                      output logic e_sdo, e_oe, e_sync);
    int p;
    bit half, data;
    logic [15:0] w;
    half = (k >= 32);
    p = k % 32;
    data = m_rj ? (p >= 16) : (p < 16);
    w = half ? r : l;
    e_sdo = data ? w[m_rj ? 31 - p : 15 - p] : 1'b0;
    e_oe = data | m_idle;
    e_sync = m_coinc ? !half : (k == 63 || k < 31);
  endfunction

  task automatic load_pair(input logic [15:0] l, r);
    @(negedge clk);
    left_smp = l;
    right_smp = r;
    smp_load = 1'b1;
    @(negedge clk);
    smp_load = 1'b0;
  endtask

  // capture one master frame starting at the sync rise
  task automatic master_frame(input logic [15:0] l, r, input bit mid,
                              input logic [15:0] nl, nr, input string tag);
    logic [63:0] a_sdo, a_oe, a_sy, e_sdo, e_oe, e_sy;
    logic ps, es, eo, ey;
    int k, cnt, gap_bad;
    gap_bad = 0;
    ps = sync_o;
    forever begin
      @(negedge clk);
      if (!ps && sync_o) break;
      ps = sync_o;
    end
    k = m_coinc ? 0 : 63;
    a_sdo[k] = sdo; a_oe[k] = sdo_oe; a_sy[k] = sync_o;
    if (!sclk_o) gap_bad++;
    for (int n = 1; n < 64; n++) begin
      cnt = 0;
      ps = sclk_o;
      forever begin
        @(negedge clk);
        cnt++;
        if (mid && n == 12) begin
          left_smp = nl; right_smp = nr; smp_load = 1'b1;
        end else smp_load = 1'b0;
        if (!ps && sclk_o) break;
        ps = sclk_o;
      end
      if (cnt != 2 * div) gap_bad++;
      k = (k + 1) % 64;
      a_sdo[k] = sdo; a_oe[k] = sdo_oe; a_sy[k] = sync_o;
    end
    smp_load = 1'b0;
    for (int j = 0; j < 64; j++) begin
      expect_slot(j, l, r, es, eo, ey);
      e_sdo[j] = es; e_oe[j] = eo; e_sy[j] = ey;
    end
    check(gap_bad == 0, "R1", {tag, " sclk period per slot"}, 64'(gap_bad), 64'd0);
    check(a_sdo == e_sdo, "R2/R4/R6", {tag, " sdo per slot"}, a_sdo, e_sdo);
    check(a_oe == e_oe, "R5", {tag, " sdo_oe per slot"}, a_oe, e_oe);
    check(a_sy == e_sy, m_coinc ? "R2" : "R3", {tag, " sync per slot"}, a_sy, e_sy);
  endtask

  // drive two slave frames, check the second
  task automatic slave_frames(input logic [15:0] l, r, input string tag);
    logic [63:0] a_sdo, a_oe, e_sdo, e_oe;
    logic es, eo, ey;
    int pins;
    pins = 0;
    for (int f = 0; f < 2; f++) begin
      for (int j = 0; j < 64; j++) begin
        ext_sync = m_coinc ? (j < 32) : (j == 63 || j < 31);
        ext_sclk = 1'b1;
        repeat (4) @(negedge clk);
        ext_sclk = 1'b0;
        repeat (4) @(negedge clk);
        if (f == 1) begin
          a_sdo[j] = sdo; a_oe[j] = sdo_oe;
        end
        if (sync_o || sclk_o) pins++;
      end
    end
    for (int j = 0; j < 64; j++) begin
      expect_slot(j, l, r, es, eo, ey);
      e_sdo[j] = es; e_oe[j] = eo;
    end
    check(a_sdo == e_sdo, "R7", {tag, " slave sdo per slot"}, a_sdo, e_sdo);
    check(a_oe == e_oe, "R7", {tag, " slave sdo_oe per slot"}, a_oe, e_oe);
    check(pins == 0, "R8", {tag, " slave sync_o/sclk_o low"}, 64'(pins), 64'd0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check({sdo, sdo_oe, sync_o, sclk_o} == 4'b0, "R9", "outputs in reset",
          64'({sdo, sdo_oe, sync_o, sclk_o}), 64'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_master_modes();
    logic [15:0] l, r;
    for (int i = 0; i < 8; i++) begin
      m_coinc = i[0]; m_rj = i[1]; m_idle = i[2];
      div = (i[0] ^ i[1]) ? 2 : 1;
      l = 16'h8001 ^ 16'(i * 16'h1357);
      r = 16'h7FFE ^ 16'(i * 16'h2468);
      load_pair(l, r);
      repeat (600) @(negedge clk);
      master_frame(l, r, 1'b0, '0, '0, $sformatf("master mode %0d", i));
    end
  endtask

  task automatic t_mid_load();
    m_coinc = 1'b1; m_rj = 1'b0; m_idle = 1'b1; div = 1;
    load_pair(16'hC0DE, 16'h1234);
    repeat (300) @(negedge clk);
    master_frame(16'hC0DE, 16'h1234, 1'b1, 16'h0F0F, 16'hF00D, "R6 frame with mid load");
    master_frame(16'h0F0F, 16'hF00D, 1'b0, '0, '0, "R6 following frame");
  endtask

  task automatic t_power_down();
    m_coinc = 1'b1; m_rj = 1'b0; m_idle = 1'b0; div = 1;
    load_pair(16'hB00C, 16'h5A5A);
    repeat (300) @(negedge clk);
    pwr_dn = 1'b1;
    repeat (3) @(negedge clk);
    check({sdo, sdo_oe, sync_o, sclk_o} == 4'b0, "R9", "outputs in power-down",
          64'({sdo, sdo_oe, sync_o, sclk_o}), 64'd0);
    pwr_dn = 1'b0;
    @(negedge clk);
    check({sclk_o, sync_o, sdo_oe, sdo} == 4'b1111, "R9", "first slot after release",
          64'({sclk_o, sync_o, sdo_oe, sdo}), 64'hF);
    master_frame(16'hB00C, 16'h5A5A, 1'b0, '0, '0, "R9 frame after release");
  endtask

  task automatic t_slave_modes();
    logic [15:0] l, r;
    m_slave = 1'b1; div = 1;
    for (int i = 0; i < 8; i++) begin
      m_coinc = i[0]; m_rj = i[1]; m_idle = i[2];
      l = 16'hA5C3 ^ 16'(i * 16'h0F1D);
      r = 16'h3C5A ^ 16'(i * 16'h7A11);
      load_pair(l, r);
      @(negedge clk);
      slave_frames(l, r, $sformatf("slave mode %0d", i));
    end
    m_slave = 1'b0;
  endtask

  initial begin
    t_reset();
    t_master_modes();
    t_mid_load();
    t_power_down();
    t_slave_modes();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end
endmodule